// File: doc/BRIEF.md
# Reset Sequencer with Configuration Strap Capture

This block accepts an active-low reset that may change at any moment relative to the system clock. It turns that reset into a clean, active-high internal reset. Assertion reaches the internal reset at once. Release passes through a two-stage synchronizer. Once the internal reset has released, a countdown runs for a fixed number of cycles. At the end of the countdown the block issues a one-cycle fetch-start strobe, and at the same moment it presents the 20-bit start address `20'hFFFF0`.

On the release cycle the block samples a configuration strap pin. It keeps that value until the next reset. The kept value decides how the multiplexed address/data bus behaves in the address phase of chip-select cycles:
- Strap high: a per-region disable-address bit can stop the bus from driving address. The address is then found only on the dedicated address lines.
- Strap low: the bus always drives address and data, whatever that bit says.

A width monitor measures each low pulse on the raw reset. It marks a pulse as invalid when the pulse lasted four clock periods or fewer.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n_raw` is low, `sys_rst` is 1 without waiting for a clock edge. After `rst_n_raw` rises, `sys_rst` stays 1 at the first rising clock edge and drops to 0 at the second.
- R2: `fetch_go` is 1 for exactly one cycle. It is registered at the 7th rising edge after the edge at which `sys_rst` dropped.
- R3: `start_addr` is 0 while in reset and until the fetch strobe. From the cycle of `fetch_go` onward it reads `20'hFFFF0`.
- R4: `strap_q` is 0 while in reset. At the edge where `sys_rst` drops it takes the value of `strap_in`.
- R5: After capture, changes on `strap_in` have no effect on `strap_q` until the next reset.
- R6: One cycle after the inputs, `ad_addr_en` is 1 when the captured strap is 1 and `dis_addr` is 0. It is 0 when the captured strap is 1 and `dis_addr` is 1.
- R7: When the captured strap is 0, `ad_addr_en` is 1 whatever the value of `dis_addr`.
- R8: If `rst_n_raw` falls again before the fetch strobe, the countdown is abandoned and no `fetch_go` occurs. A later release restarts the full sequence.
- R9: A few cycles after a reset release, `rst_short` is 1 if the low pulse covered four or fewer rising clock edges, and 0 if it covered five or more. The flag clears when the next reset begins.
- R10: While in reset, `fetch_go` is 0 and `ad_addr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n_raw | input | 1 | Raw active-low reset, asynchronous |
| strap_in | input | 1 | Configuration strap pin (pulled high) |
| dis_addr | input | 1 | Region disable-address control bit |
| sys_rst | output | 1 | Synchronized active-high internal reset |
| fetch_go | output | 1 | One-cycle fetch-start strobe |
| start_addr | output | 20 | Start address, valid from the strobe onward |
| strap_q | output | 1 | Captured strap value |
| ad_addr_en | output | 1 | Multiplexed bus drives address in the address phase |
| rst_short | output | 1 | Last reset pulse was too short |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a fetch latency of 7 and a minimum pulse of 4 cycles. These values are small enough to sweep every reset pulse width from 1 to 8 cycles, which covers both sides of the validity threshold. For each release the bench tracks, cycle by cycle, the reset, strobe, address and strap outputs. It aborts the countdown at each of its seven positions and drives all four combinations of strap and disable bit.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int ADDR_W        = 20;
  localparam int DEF_STAGES    = 2;
  localparam int DEF_FETCH_LAT = 7;
  localparam int DEF_MIN_LOW   = 4;
  localparam logic [ADDR_W-1:0] DEF_VECTOR = 20'hFFFF0;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out,
  output logic rel_now
);
  localparam int S = (STAGES < 2) ? 2 : STAGES;
  logic [S-1:0] stage;

  // stage[0] is nearest the raw input; all stages set at once on assertion
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= '1;
    else         stage <= {stage[S-2:0], 1'b0};
  end

  assign rst_out = stage[S-1];
  // last stage still in reset while the one before it has released
  assign rel_now = stage[S-1] & ~stage[S-2];
endmodule

// File: rtl/rstseq_release.sv
module rstseq_release
  import rstseq_pkg::*;
#(
  parameter int    FETCH_LAT = DEF_FETCH_LAT,
  parameter addr_t VECTOR    = DEF_VECTOR
) (
  input  logic  clk,
  input  logic  arst_n,
  input  logic  sys_rst,
  output logic  fetch_go,
  output addr_t start_addr
);
  localparam int CW = $clog2(FETCH_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(FETCH_LAT - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt        <= '0;
      done       <= 1'b0;
      fetch_go   <= 1'b0;
      start_addr <= '0;
    end else begin
      fetch_go <= 1'b0;
      if (!sys_rst && !done) begin
        if (cnt == LAST) begin
          done       <= 1'b1;
          fetch_go   <= 1'b1;
          start_addr <= VECTOR;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap (
  input  logic clk,
  input  logic arst_n,
  input  logic rel_now,
  input  logic strap_in,
  input  logic dis_addr,
  output logic strap_q,
  output logic ad_addr_en
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      strap_q    <= 1'b0;
      ad_addr_en <= 1'b1;
    end else begin
      if (rel_now) strap_q <= strap_in;
      ad_addr_en <= ~strap_q | ~dis_addr;
    end
  end
endmodule

// File: rtl/rstseq_width.sv
module rstseq_width #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_short
);
  localparam int WW = $clog2(MIN_LOW + 2);
  localparam logic [WW-1:0] SAT = WW'(MIN_LOW + 1);
  localparam logic [WW-1:0] LIM = WW'(MIN_LOW);

  // free-running monitor, power-up values only
  logic          m1 = 1'b1;
  logic          m2 = 1'b1;
  logic          m3 = 1'b1;
  logic [WW-1:0] wcnt = '0;
  logic          short_r = 1'b0;

  always_ff @(posedge clk) begin
    m1 <= rst_n_raw;
    m2 <= m1;
    m3 <= m2;
    if (!m2) begin
      if (wcnt != SAT) wcnt <= wcnt + 1'b1;
      short_r <= 1'b0;
    end else begin
      wcnt <= '0;
      if (!m3) short_r <= (wcnt <= LIM);
    end
  end

  assign rst_short = short_r;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int    STAGES    = DEF_STAGES,
  parameter int    FETCH_LAT = DEF_FETCH_LAT,
  parameter int    MIN_LOW   = DEF_MIN_LOW,
  parameter addr_t VECTOR    = DEF_VECTOR
) (
  input  logic        clk,
  input  logic        rst_n_raw,
  input  logic        strap_in,
  input  logic        dis_addr,
  output logic        sys_rst,
  output logic        fetch_go,
  output logic [19:0] start_addr,
  output logic        strap_q,
  output logic        ad_addr_en,
  output logic        rst_short
);
  logic rel_now;

  rstseq_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n_raw), .rst_out(sys_rst), .rel_now(rel_now)
  );

  rstseq_release #(.FETCH_LAT(FETCH_LAT), .VECTOR(VECTOR)) u_rel (
    .clk(clk), .arst_n(rst_n_raw), .sys_rst(sys_rst),
    .fetch_go(fetch_go), .start_addr(start_addr)
  );

  rstseq_strap u_strap (
    .clk(clk), .arst_n(rst_n_raw), .rel_now(rel_now), .strap_in(strap_in),
    .dis_addr(dis_addr), .strap_q(strap_q), .ad_addr_en(ad_addr_en)
  );

  rstseq_width #(.MIN_LOW(MIN_LOW)) u_width (
    .clk(clk), .rst_n_raw(rst_n_raw), .rst_short(rst_short)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic        clk,
  input logic        rst_n_raw,
  input logic        sys_rst,
  input logic        fetch_go,
  input logic [19:0] start_addr,
  input logic        strap_q,
  input logic        dis_addr,
  input logic        ad_addr_en
);
  // R2
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    fetch_go |=> !fetch_go);
  // R10
  fetch_out_of_rst_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    fetch_go |-> !sys_rst);
  // R3
  vector_at_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    fetch_go |-> (start_addr == 20'hFFFF0));
  // R5
  strap_held_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    (!sys_rst && !$past(sys_rst)) |-> $stable(strap_q));
  // R7
  strap_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    (!strap_q && !sys_rst) |=> ad_addr_en);
  // R6
  dis_addr_block_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    (strap_q && dis_addr) |=> !ad_addr_en);
endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk(clk), .rst_n_raw(rst_n_raw), .sys_rst(sys_rst), .fetch_go(fetch_go),
  .start_addr(start_addr), .strap_q(strap_q), .dis_addr(dis_addr),
  .ad_addr_en(ad_addr_en)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n_raw = 1'b1;
  logic        strap_in = 1'b1;
  logic        dis_addr = 1'b0;
  logic        sys_rst, fetch_go, strap_q, ad_addr_en, rst_short;
  logic [19:0] start_addr;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [19:0] VEC = 20'hFFFF0;
  localparam int FLAT = 7;

  always #10 clk = ~clk;

  rstseq_top u_rstseq_top (
    .clk(clk), .rst_n_raw(rst_n_raw), .strap_in(strap_in), .dis_addr(dis_addr),
    .sys_rst(sys_rst), .fetch_go(fetch_go), .start_addr(start_addr),
    .strap_q(strap_q), .ad_addr_en(ad_addr_en), .rst_short(rst_short)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // assert for n cycles, then release with strap value s and follow the sequence
  task automatic run_reset(input int n, input logic s);
    @(negedge clk);
    rst_n_raw = 1'b0;
    #1;
    chk("R1 async assert", sys_rst, 1);
    chk("R10 fetch idle in reset", fetch_go, 0);
    chk("R10 bus enable in reset", ad_addr_en, 1);
    chk("R3 addr cleared", start_addr, 0);
    chk("R4 strap cleared", strap_q, 0);
    strap_in = s;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk);
    rst_n_raw = 1'b1;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      chk("R1 release timing", sys_rst, (cyc < 2) ? 1 : 0);
      chk("R2 fetch timing", fetch_go, (cyc == 2 + FLAT) ? 1 : 0);
      chk("R3 start addr", start_addr, (cyc >= 2 + FLAT) ? VEC : 0);
      chk("R4 strap capture", strap_q, (cyc >= 2) ? s : 0);
    end
    chk("R9 short flag", rst_short, (n <= 4) ? 1 : 0);
  endtask

  initial begin
    #1 rst_n_raw = 1'b0;
    repeat (6) @(negedge clk);
    rst_n_raw = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 power-up release", sys_rst, 0);

    // pulse-width sweep, both strap values
    for (int n = 1; n <= 8; n++)
      for (int s = 0; s <= 1; s++) begin
        run_reset(n, s[0]);
        // strap/disable combinations
        for (int d = 0; d <= 1; d++) begin
          dis_addr = d[0];
          @(negedge clk);
          if (s == 0) chk("R7 strap low drives", ad_addr_en, 1);
          else        chk("R6 disable gate", ad_addr_en, d[0] ? 0 : 1);
        end
        dis_addr = 1'b0;
        strap_in = ~s[0];
        repeat (2) @(negedge clk);
        chk("R5 strap ignored", strap_q, s[0]);
        strap_in = 1'b1;
      end

    // abort the countdown at every position
    for (int k = 0; k < FLAT; k++) begin
      @(negedge clk);
      rst_n_raw = 1'b0;
      repeat (6) @(negedge clk);
      rst_n_raw = 1'b1;
      for (int c = 1; c <= 2 + k; c++) begin
        @(negedge clk);
        chk("R8 no fetch before abort", fetch_go, 0);
      end
      rst_n_raw = 1'b0;
      #1;
      chk("R8 abort resets", sys_rst, 1);
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        chk("R8 no fetch after abort", fetch_go, 0);
      end
      run_reset(6, 1'b1);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule